// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits in the column path of an SDRAM controller and turns one burst request into a run of column addresses, one per clock. A request supplies the first column, a three-bit length code and a wrap-order bit taken from the programmed mode value, and a read/write flag. The block then steps through the burst, raises a final-beat flag on the closing beat of any fixed-length burst, and stops early when the controller asserts terminate.

Two wrap orders are supported. Sequential order adds the beat number to the start column inside the aligned block of the burst length. Interleaved order XORs the beat number into the low start bits. A page-length burst runs in sequential order only, wraps around the whole row and continues until it is terminated. A single-write mode turns every write burst into one beat while reads keep the programmed length. An illegal length setting is reported and no beats are produced.

Top module: `burst_colseq`

## Requirements
- R1: In sequential order (wrap bit = 0), beat i has column (start & ~M) | ((start + i) & M), where M = length - 1. The bits above M are held for the whole burst.
- R2: In interleaved order (wrap bit = 1), beat i has column (start & ~M) | ((start ^ i) & M).
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `beat_last` is high on the final beat only, and `beat_valid` falls on the next cycle unless a new burst starts.
- R4: Length code 7 with sequential order is a page burst. Its column is (start + i) mod 2^COL_W (512 columns by default). It runs past 2^COL_W beats without stopping, and `beat_last` never rises during it.
- R5: Length code 7 with interleaved order, or any of the codes 4, 5 and 6, is illegal. An accepted start with such a setting raises `mode_err` for exactly the next cycle, and no beat is produced.
- R6: When `single_wr` is high, a write start produces one beat (the start column) with `beat_last` high. A read start keeps the programmed length. When `single_wr` is low, writes also keep the programmed length.
- R7: When `term` is high during a beat, that beat is the last one: `beat_valid` is low on the next cycle. This applies to both fixed and page bursts.
- R8: A start is accepted when the block is idle, on a final beat, or on a terminated beat. Its first beat appears one cycle later. A start during any other beat of a running burst is ignored.
- R9: After reset, `beat_valid`, `beat_last` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Burst request strobe |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code: 0/1/2/3 = 1/2/4/8 beats, 7 = page |
| wrap_ilv | input | 1 | Wrap order: 0 = sequential, 1 = interleaved |
| single_wr | input | 1 | Forces write bursts to one beat |
| term | input | 1 | Ends the burst after the current beat |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat closes a fixed-length burst |
| mode_err | output | 1 | Pulse: the accepted start had an illegal setting |

## Verification
Sequential and interleaved bursts are started from columns that are unaligned and that sit close to the top of a block. Only then do the two orders produce different column lists. An add that carries into the held upper bits would also show up there. Page bursts are started near the end of the row and one of them runs longer than a full row. This separates a proper modulo wrap from an early stop or a stray final-beat flag. Other runs cover single-write mode with reads and writes, terminate on fixed and page bursts, back-to-back starts, starts ignored in mid-burst, and both kinds of illegal setting. These show that the length is chosen per request and that acceptance follows the stated rules.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;

   typedef enum logic {
      WRAP_SEQ = 1'b0,
      WRAP_ILV = 1'b1
   } wrap_e;

   localparam logic [2:0] LEN_1    = 3'd0;
   localparam logic [2:0] LEN_2    = 3'd1;
   localparam logic [2:0] LEN_4    = 3'd2;
   localparam logic [2:0] LEN_8    = 3'd3;
   localparam logic [2:0] LEN_PAGE = 3'd7;

   // widest fixed burst is 8 beats -> 3 column bits
   localparam int FIXED_LOG2 = 3;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_colseq_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [2:0]       len_code,
   input  logic             ilv,
   input  logic             is_write,
   input  logic             single_wr,
   output logic [COL_W-1:0] mask,
   output logic             page,
   output logic             illegal
);

   localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

   logic       force_one;
   logic [2:0] eff_code;

   // legality is judged on the programmed setting, not the forced one
   always_comb begin
      illegal = 1'b0;
      if (len_code == LEN_PAGE && wrap_e'(ilv) == WRAP_ILV)
         illegal = 1'b1;
      else if (len_code > LEN_8 && len_code != LEN_PAGE)
         illegal = 1'b1;
   end

   assign force_one = is_write && single_wr;
   assign eff_code  = force_one ? LEN_1 : len_code;

   always_comb begin
      mask = '0;
      page = 1'b0;
      unique case (eff_code)
         LEN_1:    mask = '0;
         LEN_2:    mask = COL_W'(1);
         LEN_4:    mask = COL_W'(3);
         LEN_8:    mask = COL_W'(7);
         LEN_PAGE: begin
            mask = ALL_ONES;
            page = 1'b1;
         end
         default:  mask = '0;
      endcase
   end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + W'(1);
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_colseq_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  wrap_e            order,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] seq_sum;

   // carries out of the masked field are discarded by the per-bit select
   assign seq_sum = base + cnt;

   generate
      for (genvar b = 0; b < COL_W; b++) begin : g_bit
         if (b < FIXED_LOG2) begin : g_low
            // low bits may wrap in either order
            assign col[b] = !mask[b]           ? base[b] :
                            (order == WRAP_ILV) ? (base[b] ^ cnt[b]) :
                                                  seq_sum[b];
         end else begin : g_high
            // upper bits only move in a page burst, which is sequential
            assign col[b] = mask[b] ? seq_sum[b] : base[b];
         end
      end
   endgenerate

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
   import burst_colseq_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             wrap_ilv,
   input  logic             single_wr,
   input  logic             term,
   output logic [COL_W-1:0] col_addr,
   output logic             beat_valid,
   output logic             beat_last,
   output logic             mode_err
);

   generate
      if (COL_W < FIXED_LOG2 + 1) begin : g_bad_width
         $error("burst_colseq: COL_W must exceed the widest fixed burst field");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_page;
   logic             dec_illegal;

   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   wrap_e            order_q;
   logic             page_q;
   logic             active_q;
   logic             err_q;
   logic [COL_W-1:0] cnt;
   logic             accept;

   burst_len_decode #(.COL_W(COL_W)) u_dec (
      .len_code  (len_code),
      .ilv       (wrap_ilv),
      .is_write  (is_write),
      .single_wr (single_wr),
      .mask      (dec_mask),
      .page      (dec_page),
      .illegal   (dec_illegal)
   );

   assign accept = start && (!active_q || beat_last || term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         mask_q   <= '0;
         order_q  <= WRAP_SEQ;
         page_q   <= 1'b0;
         active_q <= 1'b0;
         err_q    <= 1'b0;
      end else if (accept) begin
         err_q    <= dec_illegal;
         active_q <= !dec_illegal;
         base_q   <= start_col;
         mask_q   <= dec_mask;
         order_q  <= wrap_e'(wrap_ilv);
         page_q   <= dec_page;
      end else begin
         err_q <= 1'b0;
         if (active_q && (beat_last || term))
            active_q <= 1'b0;
      end
   end

   burst_beat_counter #(.W(COL_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (active_q),
      .cnt   (cnt)
   );

   burst_addr_gen #(.COL_W(COL_W)) u_addr (
      .base  (base_q),
      .cnt   (cnt),
      .mask  (mask_q),
      .order (order_q),
      .col   (col_addr)
   );

   assign beat_valid = active_q;
   assign beat_last  = active_q && !page_q && (cnt == mask_q);
   assign mode_err   = err_q;

   // ---------------- assertions ----------------
   assert_last_in_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid);

   assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last && !start) |=> !beat_valid);

   assert_term_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && term && !start) |=> !beat_valid);

   assert_err_no_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !beat_valid);

   assert_upper_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && !term && !start) |=>
         (beat_valid && ((col_addr & ~mask_q) == $past(col_addr & ~mask_q))));

   assert_first_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !beat_valid && !dec_illegal) |=>
         (beat_valid && col_addr == $past(start_col)));

   assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && is_write && single_wr && !dec_illegal) |->
         (dec_mask == '0 && !dec_page));

endmodule

// File: tb/burst_colseq_test.sv
module burst_colseq_test;

   localparam int COL_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             is_write = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0]       len_code = '0;
   logic             wrap_ilv = 1'b0;
   logic             single_wr = 1'b0;
   logic             term = 1'b0;
   logic [COL_W-1:0] col_addr;
   logic             beat_valid;
   logic             beat_last;
   logic             mode_err;

   int checks = 0;
   int bad = 0;
   int cycles = 0;

   typedef struct packed {
      logic [3:0]       req;
      logic             last;
      logic [COL_W-1:0] col;
   } item_t;

   item_t q[$];

   always #2 clk = ~clk;

   burst_colseq #(.COL_W(COL_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
      .start_col(start_col), .len_code(len_code), .wrap_ilv(wrap_ilv),
      .single_wr(single_wr), .term(term), .col_addr(col_addr),
      .beat_valid(beat_valid), .beat_last(beat_last), .mode_err(mode_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int len_of(input logic [2:0] code);
      case (code)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         default: return 512;
      endcase
   endfunction

   function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] b, input int i,
                                               input int len, input bit ilv);
      logic [COL_W-1:0] m;
      logic [COL_W-1:0] iv;
      m  = COL_W'(len - 1);
      iv = COL_W'(i);
      if (ilv) return (b & ~m) | ((b ^ iv) & m);
      return (b & ~m) | ((b + iv) & m);
   endfunction

   // push nbeats expected items; a fixed burst flags its final beat
   task automatic expect_beats(input logic [COL_W-1:0] b, input int len, input bit ilv,
                               input int nbeats, input int req);
      for (int i = 0; i < nbeats; i++) begin
         item_t it;
         it.req  = 4'(req);
         it.col  = exp_col(b, i, len, ilv);
         it.last = (len != 512) && (i == len - 1);
         q.push_back(it);
      end
   endtask

   // called at a falling edge; returns one falling edge later
   task automatic pulse_start(input logic [COL_W-1:0] c, input logic [2:0] code,
                              input bit ilv, input bit wr, input bit sw);
      start_col = c; len_code = code; wrap_ilv = ilv; is_write = wr; single_wr = sw;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain;
      do @(posedge clk); while (q.size() != 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input logic [COL_W-1:0] c, input logic [2:0] code, input bit ilv,
                      input int req);
      expect_beats(c, len_of(code), ilv, len_of(code), req);
      pulse_start(c, code, ilv, 1'b0, 1'b0);
      drain();
   endtask

   // monitor: compares each presented beat with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && beat_valid) begin
         if (q.size() == 0) begin
            checks++; bad++;
            $display("FAIL R8 unexpected beat actual=%0d expected=none", col_addr);
         end else begin
            item_t e;
            e = q.pop_front();
            chk(col_addr == e.col, $sformatf("R%0d column", e.req), col_addr, e.col);
            chk(beat_last == e.last, $sformatf("R%0d last flag", e.req), beat_last, e.last);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++; checks++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(!beat_valid && !beat_last && !mode_err, "R9 reset outputs", beat_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!beat_valid && !mode_err, "R9 idle after reset", beat_valid, 0);

      // R1 / R3 sequential, every fixed length, unaligned starts
      run(9'h000, 3'd0, 1'b0, 3);
      run(9'h0A5, 3'd1, 1'b0, 1);
      run(9'h0A7, 3'd2, 1'b0, 1);
      run(9'h1FD, 3'd3, 1'b0, 1);
      run(9'h13A, 3'd3, 1'b0, 3);
      // R2 interleaved
      run(9'h0A5, 3'd1, 1'b1, 2);
      run(9'h0A6, 3'd2, 1'b1, 2);
      run(9'h1FD, 3'd3, 1'b1, 2);
      run(9'h153, 3'd3, 1'b1, 2);

      // R4 + R7 page burst near row end, terminated on beat 4
      expect_beats(9'h1FE, 512, 1'b0, 5, 4);
      pulse_start(9'h1FE, 3'd7, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      drain();

      // R4 page burst longer than a row
      expect_beats(9'h005, 512, 1'b0, 520, 4);
      pulse_start(9'h005, 3'd7, 1'b0, 1'b1, 1'b0);
      repeat (519) @(negedge clk);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      drain();

      // R7 terminate a fixed burst on beat 2
      expect_beats(9'h020, 8, 1'b0, 3, 7);
      pulse_start(9'h020, 3'd3, 1'b0, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      drain();

      // R6 single-write mode: write shortened, read kept, mode off keeps write length
      expect_beats(9'h0C3, 1, 1'b0, 1, 6);
      pulse_start(9'h0C3, 3'd3, 1'b0, 1'b1, 1'b1);
      drain();
      expect_beats(9'h0C3, 8, 1'b0, 8, 6);
      pulse_start(9'h0C3, 3'd3, 1'b0, 1'b0, 1'b1);
      drain();
      expect_beats(9'h0C3, 4, 1'b1, 4, 6);
      pulse_start(9'h0C3, 3'd2, 1'b1, 1'b1, 1'b0);
      drain();

      // R8 back-to-back start on the final beat
      expect_beats(9'h040, 4, 1'b0, 4, 8);
      expect_beats(9'h033, 2, 1'b1, 2, 8);
      pulse_start(9'h040, 3'd2, 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      pulse_start(9'h033, 3'd1, 1'b1, 1'b0, 1'b0);
      drain();

      // R8 start in mid-burst is ignored
      expect_beats(9'h010, 8, 1'b0, 8, 8);
      pulse_start(9'h010, 3'd3, 1'b0, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      pulse_start(9'h1AA, 3'd0, 1'b1, 1'b0, 1'b0);
      drain();

      // R5 illegal settings: page with interleave, reserved code
      pulse_start(9'h011, 3'd7, 1'b1, 1'b0, 1'b0);
      chk(mode_err && !beat_valid, "R5 page+interleave flagged", mode_err, 1);
      @(negedge clk);
      chk(!mode_err && !beat_valid, "R5 error is one cycle", mode_err, 0);
      pulse_start(9'h011, 3'd5, 1'b0, 1'b0, 1'b0);
      chk(mode_err && !beat_valid, "R5 reserved code flagged", mode_err, 1);
      @(negedge clk);
      chk(!mode_err && !beat_valid, "R5 no beat after error", beat_valid, 0);

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R3 scoreboard empty", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule